// File: doc/BRIEF.md
# Memory Clock and Clock-Enable Generator

This block derives three clocks for synchronous memories and two clock-enable levels from the CPU clock. Output 0 serves a synchronous boot ROM, and outputs 1 and 2 serve two pairs of SDRAM banks. Each clock runs at either half or a quarter of the CPU clock, and each can be stopped on its own. A one-cycle write strobe with a data byte loads the rate-select, stop and enable-deassert bits. The same byte can be read back at any time.

A boot-ROM strap input changes the start-up state. When it is set, clock 0 cannot be stopped and enable 0 cannot be dropped, and enable 0 comes out of reset already high. A sleep request gates every clock low and drops enable 1. It also returns the settings to their reset values, so every clock restarts at a quarter of the CPU rate when sleep ends. A new rate or stop setting is applied only while the affected clock is low, so a high phase is never cut short by software.

Top module: `memclk_ctrl`

## Requirements
- R1: Bit i of the settings byte (i = 0..2) selects the rate of clock i. A 1 gives a period of 2 CPU cycles and a 0 gives 4 CPU cycles.
- R2: Bit 3+i stops clock i, and a stopped clock is held low.
- R3: While sleep is requested, all clocks are low from the next CPU edge onward, and writes are ignored.
- R4: After reset, and after sleep ends, the settings read back as their reset values: 0xC0 with the strap at 0, 0x80 with the strap at 1. Every clock then has a 4-cycle period.
- R5: With the strap at 1, bit 3 (stop clock 0) and bit 6 (drop enable 0) always read 0 and have no effect.
- R6: During reset, enable 0 equals the strap and enable 1 is low.
- R7: Enable 1 is low during reset and goes low on the CPU edge after sleep is requested.
- R8: Bit 6+j set to 1 drops enable j, and set to 0 raises it. The enable follows within two CPU edges of the write.
- R9: Enable 1 rises only after a write that clears bit 7. Without such a write it stays low after reset.
- R10: A rate or stop change takes effect only while the clock is low. A slow high phase that has begun lasts its full 2 cycles.
- R11: The rate and stop bits of each clock act only on that clock.
- R12: The read-back byte equals the stored settings in the same bit layout: [2:0] rate, [5:3] stop, [7:6] enable deassert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request, synchronous to clk_cpu |
| boot_strap | input | 1 | Boot-ROM strap; 1 locks clock 0 and enable 0 on |
| wr_en | input | 1 | Single-cycle settings write strobe |
| wr_data | input | 8 | Settings byte to write |
| rd_data | output | 8 | Current settings byte |
| mclk | output | 3 | Memory clocks |
| mcke | output | 2 | Memory clock enables |

## Verification
The assertions assume that the strap is a static level: it changes only while reset is held, so the lock on clock 0 and enable 0 is checked only on cycles where the strap matches the previous cycle. They also assume that sleep and the write strobe are synchronous to the CPU clock, so a single edge is enough to see their effect. The bench sets the strap only while reset is asserted. It changes sleep, strobe and data only on falling edges, which keeps every stimulus within these assumptions.

// File: rtl/memclk_pkg.sv
package memclk_pkg;
    localparam int unsigned NUM_CLK = 3;
    localparam int unsigned NUM_CKE = 2;
    localparam int unsigned CFG_W   = 2 * NUM_CLK + NUM_CKE;

    // Packed layout, MSB first: [7:6] enable deassert, [5:3] stop, [2:0] fast
    typedef struct packed {
        logic [NUM_CKE-1:0] cke_off;
        logic [NUM_CLK-1:0] off;
        logic [NUM_CLK-1:0] fast;
    } cfg_t;

    function automatic cfg_t cfg_default(input logic strap);
        cfg_t c;
        c.fast       = '0;
        c.off        = '0;
        c.cke_off    = '1;
        c.cke_off[0] = ~strap;
        return c;
    endfunction
endpackage

// File: rtl/memclk_cfg_reg.sv
module memclk_cfg_reg
    import memclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic boot_strap,
    input  logic wr_en,
    input  cfg_t wr_cfg,
    output cfg_t cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sleep_req) begin
            cfg_d = cfg_default(boot_strap);
        end else if (wr_en) begin
            cfg_d = wr_cfg;
        end
        if (boot_strap) begin
            cfg_d.off[0]     = 1'b0;
            cfg_d.cke_off[0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= cfg_default(boot_strap);
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R5: strap held for a cycle keeps the lock bits clear
    a_r5_strap_lock: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(boot_strap) && boot_strap) |-> (!cfg_q.off[0] && !cfg_q.cke_off[0]));
endmodule

// File: rtl/memclk_div_out.sv
module memclk_div_out (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sel_fast,
    input  logic sel_off,
    output logic clk_out
);
    typedef struct packed {
        logic out;
        logic ph;
        logic act_fast;
        logic act_off;
    } div_t;

    div_t div_d, div_q;
    logic eff_fast, eff_off;

    always_comb begin
        // Take new settings only while the output is low
        if (!div_q.out) begin
            eff_fast = sel_fast;
            eff_off  = sel_off;
        end else begin
            eff_fast = div_q.act_fast;
            eff_off  = div_q.act_off;
        end
        div_d          = div_q;
        div_d.act_fast = eff_fast;
        div_d.act_off  = eff_off;
        if (sleep_req || eff_off) begin
            div_d.out = 1'b0;
            div_d.ph  = 1'b0;
        end else if (eff_fast) begin
            div_d.out = ~div_q.out;
            div_d.ph  = 1'b0;
        end else begin
            div_d.ph  = ~div_q.ph;
            div_d.out = div_q.ph ? ~div_q.out : div_q.out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign clk_out = div_q.out;

    // R3: sleep forces the clock low on the next edge
    a_r3_sleep_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !clk_out);

    // R10: a slow high phase that has begun lasts two cycles
    a_r10_slow_high_full: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(div_q.out) && !div_q.act_fast && !sleep_req) |=> div_q.out);

    // R1: in fast mode a high cycle is followed by a low one
    a_r1_fast_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.out && div_q.act_fast && !sleep_req) |=> !div_q.out);
endmodule

// File: rtl/memclk_cke.sv
module memclk_cke
    import memclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               boot_strap,
    input  logic [NUM_CKE-1:0] cke_off,
    output logic [NUM_CKE-1:0] cke
);
    logic [NUM_CKE-1:0] cke_d, cke_q, cke_rst;

    always_comb begin
        cke_rst    = '0;
        cke_rst[0] = boot_strap;
        cke_d      = ~cke_off;
        if (sleep_req) cke_d[NUM_CKE-1:1] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_q <= cke_rst;
        else        cke_q <= cke_d;
    end

    assign cke = cke_q;

    // R7: enable 1 low the edge after a sleep request
    a_r7_sleep_cke1_low: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !cke_q[1]);
endmodule

// File: rtl/memclk_ctrl.sv
module memclk_ctrl
    import memclk_pkg::*;
(
    input  logic               clk_cpu,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               boot_strap,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W-1:0]   rd_data,
    output logic [NUM_CLK-1:0] mclk,
    output logic [NUM_CKE-1:0] mcke
);
    cfg_t cfg;

    memclk_cfg_reg u_cfg (
        .clk        (clk_cpu),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .boot_strap (boot_strap),
        .wr_en      (wr_en),
        .wr_cfg     (cfg_t'(wr_data)),
        .cfg        (cfg)
    );

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_div
        memclk_div_out u_div (
            .clk       (clk_cpu),
            .rst_n     (rst_n),
            .sleep_req (sleep_req),
            .sel_fast  (cfg.fast[i]),
            .sel_off   (cfg.off[i]),
            .clk_out   (mclk[i])
        );
    end

    memclk_cke u_cke (
        .clk        (clk_cpu),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .boot_strap (boot_strap),
        .cke_off    (cfg.cke_off),
        .cke        (mcke)
    );

    assign rd_data = cfg;

    // R9: enable 1 rises only two edges after a write clearing bit 7
    a_r9_cke1_after_write: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $rose(mcke[1]) |-> ($past(wr_en, 2) && !$past(wr_data[7], 2)));
endmodule

// File: tb/tb_memclk_ctrl.sv
`timescale 1ns/1ps
module tb_memclk_ctrl;
    logic       clk_cpu = 1'b0;
    logic       rst_n, sleep_req, boot_strap, wr_en;
    logic [7:0] wr_data, rd_data;
    logic [2:0] mclk;
    logic [1:0] mcke;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk_cpu = ~clk_cpu;

    memclk_ctrl dut (
        .clk_cpu(clk_cpu), .rst_n(rst_n), .sleep_req(sleep_req),
        .boot_strap(boot_strap), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mclk(mclk), .mcke(mcke)
    );

    // {write byte, period clk0, period clk1, period clk2, expected enables}
    localparam logic [21:0] VEC [0:6] = '{
        {8'h00, 4'd4, 4'd4, 4'd4, 2'b11},
        {8'h07, 4'd2, 4'd2, 4'd2, 2'b11},
        {8'h15, 4'd2, 4'd0, 4'd2, 2'b11},
        {8'h3A, 4'd0, 4'd0, 4'd0, 2'b11},
        {8'h82, 4'd4, 4'd2, 4'd4, 2'b01},
        {8'h46, 4'd4, 4'd2, 4'd2, 2'b10},
        {8'hC8, 4'd0, 4'd4, 4'd4, 2'b00}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk_cpu);
        rst_n = 0; boot_strap = strap; sleep_req = 0; wr_en = 0; wr_data = '0;
        repeat (3) @(negedge clk_cpu);
    endtask

    task automatic release_reset();
        rst_n = 1;
        @(negedge clk_cpu);
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk_cpu);
        wr_en = 1; wr_data = d;
        @(negedge clk_cpu);
        wr_en = 0;
    endtask

    // Cycles between two rising edges; 0 when fewer than two rises in 20 cycles
    task automatic measure(input int idx, output int per);
        logic prev, cur;
        int first;
        first = -1; per = 0;
        prev = mclk[idx];
        for (int n = 0; n < 20; n++) begin
            @(negedge clk_cpu);
            cur = mclk[idx];
            if (cur && !prev) begin
                if (first < 0) first = n;
                else if (per == 0) per = n - first;
            end
            prev = cur;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_cpu);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per;
        int lows;
        logic prev;
        rst_n = 0; sleep_req = 0; boot_strap = 0; wr_en = 0; wr_data = '0;

        // Reset state, strap 0 (R6, R7, R4, R12)
        do_reset(1'b0);
        chk("R6 enables in reset strap0", mcke, 2'b00);
        release_reset();
        chk("R4 default readback strap0", rd_data, 8'hC0);
        for (int i = 0; i < 3; i++) begin
            measure(i, per);
            chk("R4 default period", per, 4);
        end
        chk("R9 enable1 stays low without write", mcke[1], 0);

        // Vector table (R1, R2, R8, R11, R12)
        for (int v = 0; v < 7; v++) begin
            logic [21:0] e;
            e = VEC[v];
            write_cfg(e[21:14]);
            repeat (3) @(negedge clk_cpu);
            chk("R12 readback", rd_data, e[21:14]);
            chk("R8 enables", mcke, e[1:0]);
            measure(0, per); chk("R1 R2 R11 clk0 period", per, e[13:10]);
            measure(1, per); chk("R1 R2 R11 clk1 period", per, e[9:6]);
            measure(2, per); chk("R1 R2 R11 clk2 period", per, e[5:2]);
        end

        // Stop during a slow high phase (R10)
        write_cfg(8'hC0);
        repeat (4) @(negedge clk_cpu);
        prev = mclk[0];
        for (int n = 0; n < 10; n++) begin
            @(negedge clk_cpu);
            if (mclk[0] && !prev) break;
            prev = mclk[0];
        end
        wr_en = 1; wr_data = 8'hC8;
        @(negedge clk_cpu);
        wr_en = 0;
        chk("R10 high phase held after stop write", mclk[0], 1);
        @(negedge clk_cpu);
        chk("R10 clock low after full high phase", mclk[0], 0);
        lows = 0;
        repeat (8) begin
            @(negedge clk_cpu);
            if (!mclk[0]) lows++;
        end
        chk("R2 stopped clock stays low", lows, 8);

        // Sleep (R3, R7, R4)
        write_cfg(8'h07);
        repeat (3) @(negedge clk_cpu);
        chk("R8 enables before sleep", mcke, 2'b11);
        sleep_req = 1;
        @(negedge clk_cpu);
        chk("R3 clocks low in sleep", mclk, 3'b000);
        chk("R7 enable1 low in sleep", mcke[1], 0);
        wr_en = 1; wr_data = 8'h07;
        @(negedge clk_cpu);
        wr_en = 0;
        lows = 0;
        repeat (10) begin
            @(negedge clk_cpu);
            if (mclk == 3'b000) lows++;
        end
        chk("R3 clocks held low through sleep", lows, 10);
        chk("R3 write ignored in sleep", rd_data, 8'hC0);
        sleep_req = 0;
        @(negedge clk_cpu);
        chk("R4 readback after sleep", rd_data, 8'hC0);
        chk("R7 enable1 low after sleep", mcke[1], 0);
        for (int i = 0; i < 3; i++) begin
            measure(i, per);
            chk("R4 period after sleep", per, 4);
        end

        // Strap set (R6, R4, R5)
        do_reset(1'b1);
        chk("R6 enables in reset strap1", mcke, 2'b01);
        release_reset();
        chk("R4 default readback strap1", rd_data, 8'h80);
        write_cfg(8'h49);
        repeat (3) @(negedge clk_cpu);
        chk("R5 lock bits read zero", rd_data, 8'h01);
        chk("R5 enable0 kept high", mcke, 2'b11);
        measure(0, per);
        chk("R5 clk0 not stoppable", per, 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule